// File: doc/BRIEF.md
# Stereo Linear Attenuator with Ramped Soft Mute

This block applies one programmable linear gain to a stereo stream of 16-bit two's-complement samples. A 7-bit attenuation code selects the gain (127 − code)/127. Code 0 passes the audio unchanged and code 127 silences it. The gain in use never jumps. An internal gain register moves by one code step per accepted sample toward its target. So a change of setting turns into a short ramp, and a mute request fades the audio to silence over at most 127 samples instead of cutting it off.

Samples enter as a left/right pair on a valid/ready handshake and leave, scaled, one cycle after acceptance on a second valid/ready handshake. There is a single output register. The input is ready whenever that register is empty or is being drained in the same cycle. While the output is valid and not accepted, its data stays frozen, the input reports not ready, and the gain does not move. The attenuation code and the mute request are plain level inputs. They are sampled each time a pair is accepted.

Top module: `stereo_soft_atten`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and the internal gain code is 0, so the first accepted pair leaves unchanged.
- R2: Each output equals the input times (127 − g)/127, rounded to the nearest integer (magnitude rounded, sign kept), where g is the gain code in effect when the pair was accepted; the result stays in the 16-bit signed range.
- R3: While the gain code in effect is 127, both outputs are exactly 0 for any input.
- R4: The gain code starts each accepted pair at its current value and afterwards moves one step toward the target; with mute off the target is `atten_code` (7-bit unsigned).
- R5: With `mute_req` at 1 the target is 127, so from any starting gain the 128th pair accepted after mute rises, and every later pair, is silent; the fade is one step per pair, never a jump.
- R6: When `mute_req` returns to 0 the gain moves back toward `atten_code` at the same one-step-per-pair rate.
- R7: Left and right samples of one pair are scaled with the same gain code.
- R8: `in_ready` = !`out_valid` || `out_ready`; a pair is taken when `in_valid` && `in_ready`, appears on the output the next cycle, and while `out_valid` && !`out_ready` the output data holds and the gain code does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_left | input | 16 | Left sample, two's complement |
| in_right | input | 16 | Right sample, two's complement |
| atten_code | input | 7 | Attenuation code, gain (127 − code)/127 |
| mute_req | input | 1 | 1 requests a ramped fade to silence |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream takes the output pair |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |

## Verification
On every cycle the assertions check several behaviours. The gain code moves by exactly one step toward its target on each accepted pair and stays still otherwise, including under back-pressure. A full gain code gives a zero lane result. No lane result exceeds its input in magnitude. A stalled output pair is held steady. Only the bench's scenarios can show that the rounded values are arithmetically right across every gain code, that a mute started from a mid setting reaches silence within the promised number of pairs and comes back after release, and that both channels track one gain while the stream is stalled and released.

// File: rtl/satt_pkg.sv
`timescale 1ns/1ps
package satt_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_dir_e;
endpackage

// File: rtl/satt_gain_ramp.sv
`timescale 1ns/1ps
module satt_gain_ramp #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              mute,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] gain
);
  import satt_pkg::*;

  localparam logic [CODE_W-1:0] GMAX = {CODE_W{1'b1}};

  logic [CODE_W-1:0] target;
  step_dir_e         dir;

  always_comb begin
    target = mute ? GMAX : code;
    if (gain < target)      dir = STEP_UP;
    else if (gain > target) dir = STEP_DOWN;
    else                    dir = STEP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain <= '0;
    end else if (advance) begin
      case (dir)
        STEP_UP:   gain <= gain + 1'b1;
        STEP_DOWN: gain <= gain - 1'b1;
        default:   gain <= gain;
      endcase
    end
  end

  assert_gain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(gain));

  assert_gain_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !mute && gain < code) |=> gain == $past(gain) + 1'b1);

  assert_gain_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !mute && gain > code) |=> gain == $past(gain) - 1'b1);

  assert_mute_fade_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && mute && gain != GMAX) |=> gain == $past(gain) + 1'b1);

  assert_mute_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && mute && gain == GMAX) |=> gain == GMAX);
endmodule

// File: rtl/satt_scale_lane.sv
`timescale 1ns/1ps
module satt_scale_lane #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 7
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [CODE_W-1:0]   gain,
  output logic signed [SAMPLE_W-1:0] result
);
  localparam int GMAX_I = (1 << CODE_W) - 1;
  localparam int PROD_W = SAMPLE_W + CODE_W + 1;
  localparam logic [PROD_W-1:0] DIVISOR = PROD_W'(GMAX_I);
  localparam logic [PROD_W-1:0] HALF    = PROD_W'(GMAX_I / 2);
  localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] SAT_LO = -PROD_W'(1 << (SAMPLE_W - 1));

  logic        [CODE_W:0]   mult;
  logic signed [PROD_W-1:0] prod;
  logic                     neg;
  logic        [PROD_W-1:0] mag;
  logic        [PROD_W-1:0] quot;
  logic signed [PROD_W-1:0] signed_q;

  always_comb begin
    mult     = (CODE_W+1)'(GMAX_I) - {1'b0, gain};
    prod     = PROD_W'(sample) * $signed({{(PROD_W-CODE_W-1){1'b0}}, mult});
    neg      = prod[PROD_W-1];
    mag      = neg ? PROD_W'(-prod) : PROD_W'(prod);
    quot     = (mag + HALF) / DIVISOR;
    signed_q = neg ? -$signed(quot) : $signed(quot);
    if (signed_q > SAT_HI)      result = SAT_HI[SAMPLE_W-1:0];
    else if (signed_q < SAT_LO) result = SAT_LO[SAMPLE_W-1:0];
    else                        result = signed_q[SAMPLE_W-1:0];
  end

  logic [SAMPLE_W:0] abs_in;
  logic [SAMPLE_W:0] abs_out;
  always_comb begin
    abs_in  = sample[SAMPLE_W-1] ? (SAMPLE_W+1)'(-(SAMPLE_W+1)'(sample))
                                 : (SAMPLE_W+1)'(sample);
    abs_out = result[SAMPLE_W-1] ? (SAMPLE_W+1)'(-(SAMPLE_W+1)'(result))
                                 : (SAMPLE_W+1)'(result);
    if (!$isunknown(gain) && !$isunknown(sample)) begin
      if (gain == CODE_W'(GMAX_I))
        assert_silent_at_full_R3: assert (result == '0);
      assert_no_growth_R2: assert (abs_out <= abs_in);
    end
  end
endmodule

// File: rtl/stereo_soft_atten.sv
`timescale 1ns/1ps
module stereo_soft_atten #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  input  logic        [CODE_W-1:0]   atten_code,
  input  logic                       mute_req,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right
);
  localparam int LANES = 2;

  logic                       accept;
  logic        [CODE_W-1:0]   gain;
  logic signed [SAMPLE_W-1:0] lane_in  [LANES];
  logic signed [SAMPLE_W-1:0] lane_out [LANES];

  assign in_ready   = !out_valid || out_ready;
  assign accept     = in_valid && in_ready;
  assign lane_in[0] = in_left;
  assign lane_in[1] = in_right;

  satt_gain_ramp #(.CODE_W(CODE_W)) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (accept),
    .mute    (mute_req),
    .code    (atten_code),
    .gain    (gain)
  );

  // One scaler per channel, all fed by the same gain code (R7).
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    satt_scale_lane #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_lane (
      .sample (lane_in[ln]),
      .gain   (gain),
      .result (lane_out[ln])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_left  <= lane_out[0];
      out_right <= lane_out[1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_left) && $stable(out_right));

  assert_accept_shows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/stereo_soft_atten_test.sv
`timescale 1ns/1ps
module stereo_soft_atten_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_left = '0;
  logic signed [15:0] in_right = '0;
  logic [6:0] atten_code = '0;
  logic mute_req = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] out_left;
  logic signed [15:0] out_right;

  int checks = 0;
  int fails = 0;
  int g = 0;      // bench model of the gain code
  int k_idx = 0;  // running sample index
  bit done = 1'b0;

  stereo_soft_atten uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .atten_code(atten_code),
    .mute_req(mute_req), .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right)
  );

  always #2.5 clk = ~clk;

  function automatic int expect_scale(int s, int gc);
    int p, mag, q;
    p   = s * (127 - gc);
    mag = (p < 0) ? -p : p;
    q   = (mag + 63) / 127;
    return (p < 0) ? -q : q;
  endfunction

  function automatic int smp(int k, int ch);
    case (k % 6)
      0: return 32767;
      1: return -32768;
      2: return ch ? -1 : 1;
      default: return ((k * 7919 + ch * 12345 + 77) % 65536) - 32768;
    endcase
  endfunction

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (sample %0d, gain %0d)",
               tag, actual, expected, k_idx, g);
    end
  endtask

  function automatic void model_step();
    int tgt;
    tgt = mute_req ? 127 : int'(atten_code);
    if (g < tgt) g++;
    else if (g > tgt) g--;
  endfunction

  // Push one pair with out_ready high and check the scaled result.
  task automatic push(string tag);
    int l, r, gu;
    l = smp(k_idx, 0);
    r = smp(k_idx, 1);
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = 16'(l);
    in_right = 16'(r);
    while (!in_ready) @(negedge clk);
    gu = g;
    model_step();
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, int'(out_valid), 1);
    check((gu == 127) ? "R3" : tag, int'(out_left), expect_scale(l, gu));
    check("R7", int'(out_right), expect_scale(r, gu));
    k_idx++;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    int ga, gb;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(in_ready), 1);

    // R1/R2: unity gain right after reset
    atten_code = 7'd0;
    for (int i = 0; i < 6; i++) push("R1");

    // R4/R3: ramp down to full attenuation across every gain code
    atten_code = 7'd127;
    for (int i = 0; i < 132; i++) push("R4");

    // R4/R2: ramp back to unity
    atten_code = 7'd0;
    for (int i = 0; i < 130; i++) push("R2");

    // settle at a mid setting
    atten_code = 7'd50;
    for (int i = 0; i < 55; i++) push("R4");

    // R5: mute fade from gain 50
    mute_req = 1'b1;
    for (int i = 0; i < 140; i++) begin
      push("R5");
      if (i == 127) check("R5", int'(out_left), 0);
    end

    // R6: release ramps back to 50
    mute_req = 1'b0;
    for (int i = 0; i < 100; i++) push("R6");
    check("R6", g, 50);

    // R8: back-pressure, target moving so any extra step would show
    atten_code = 7'd127;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_left   = 16'sd20000;
    in_right  = -16'sd12345;
    ga = g;
    model_step();
    @(negedge clk);
    check("R8", int'(out_valid), 1);
    check("R8", int'(in_ready), 0);
    check("R8", int'(out_left), expect_scale(20000, ga));
    in_left  = -16'sd30000;
    in_right = 16'sd777;
    repeat (3) begin
      @(negedge clk);
      check("R8", int'(in_ready), 0);
      check("R8", int'(out_left), expect_scale(20000, ga));
      check("R8", int'(out_right), expect_scale(-12345, ga));
    end
    out_ready = 1'b1;
    gb = g;
    model_step();
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", int'(out_valid), 1);
    check("R8", int'(out_left), expect_scale(-30000, gb));
    check("R8", int'(out_right), expect_scale(777, gb));
    @(negedge clk);
    check("R8", int'(out_valid), 0);
    k_idx = 500;
    push("R4");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule